// File: doc/BRIEF.md
# Flashing Colour Palette Map

This block turns a 4-bit logical colour index, produced each dot clock by a pixel serialiser, into a 3-bit RGB value through a 16-entry table of 4-bit physical colour codes. Software loads an entry with one byte. The high nibble picks the logical entry. The low nibble carries the physical code with its three colour bits inverted. The table keeps that inverted form, and the lookup path undoes the inversion.

Physical codes 0 to 7 are steady colours. Codes 8 to 15 flash between the colour in bits 2-0 and its bitwise complement. An external flash select bit, toggled elsewhere at the flash rate, chooses which of the two is shown. The RGB output is registered, is forced to black during blanking, and follows the index one dot clock later. A write is seen by the next lookup, so a palette change during a line recolours the pixels that follow it.

The block applies no masking to the index. When the serialiser drives fewer significant bits, software must load every combination of the unused bits itself.

Top module: `palette_map`

## Requirements
- R1: While rst_ni is low, rgb_o is 0, and after reset every one of the 16 entries decodes to black.
- R2: A write with wr_en_i high and byte wr_data_i stores wr_data_i[3:0] XOR 4'b0111 as the physical code of entry wr_data_i[7:4]. Only that entry changes.
- R3: A physical code from 0 to 7 outputs its low three bits on rgb_o, with red in bit 0, green in bit 1 and blue in bit 2, whatever the value of flash_sel_i.
- R4: A physical code from 8 to 15 with flash_sel_i low outputs bits 2-0 of the code.
- R5: A physical code from 8 to 15 with flash_sel_i high outputs the bitwise complement of bits 2-0 of the code.
- R6: When blank_i is high at a clock edge, rgb_o becomes 0 after that edge.
- R7: rgb_o after a clock edge reflects the idx_i and flash_sel_i sampled at that edge. It holds until the next edge.
- R8: A write sampled at an edge is not seen by the lookup at the same edge. It is seen by the lookup at the following edge.
- R9: Entries are fully decoded, so writing one entry never alters another entry that differs from it in any one index bit.
- R10: Writes are accepted while blank_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Dot clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Palette write strobe |
| wr_data_i | input | 8 | Write byte: entry in [7:4], inverted physical code in [3:0] |
| idx_i | input | 4 | Logical colour index from the serialiser |
| flash_sel_i | input | 1 | Flash phase select |
| blank_i | input | 1 | Blanking, forces black |
| rgb_o | output | 3 | Registered colour: bit 0 red, bit 1 green, bit 2 blue |

## Verification
The bench writes an entry and reads that same entry in the same cycle. A design that bypasses the new value, or that adds a stage of delay, would show the new colour one pixel early or late. It loads flashing codes and toggles flash_sel_i. A design that inverted steady codes, or left out the stored XOR, would show the complementary colour. It writes during blanking and reads entries next to the one written. This exposes a design that drops blanked writes or ties index bits together. A reset in the middle of the run checks that the table returns to black and does not keep the colours loaded earlier.

// File: rtl/palette_map_pkg.sv
package palette_map_pkg;
  localparam int unsigned IDX_W  = 4;
  localparam int unsigned CODE_W = 4;
  localparam int unsigned RGB_W  = 3;
  localparam int unsigned N_ENT  = 1 << IDX_W;
  localparam int unsigned WR_W   = IDX_W + CODE_W;

  // stored form: colour bits inverted, flash bit plain
  localparam logic [CODE_W-1:0] STORE_XOR = CODE_W'((1 << RGB_W) - 1);

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [RGB_W-1:0]  rgb_t;

  typedef struct packed {
    idx_t  ent;
    code_t raw;
  } wr_byte_t;
endpackage

// File: rtl/palette_store.sv
module palette_store
  import palette_map_pkg::*;
#(
  parameter int unsigned ENTRIES = N_ENT
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_en_i,
  input  idx_t  wr_ent_i,
  input  code_t wr_raw_i,
  input  idx_t  rd_ent_i,
  output code_t rd_raw_o
);
  // reset to the stored form of code 0 (black)
  localparam code_t RST_RAW = STORE_XOR;

  code_t ent_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    logic hit;
    assign hit = wr_en_i && (wr_ent_i == idx_t'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  ent_q[g] <= RST_RAW;
      else if (hit) ent_q[g] <= wr_raw_i;
    end
  end

  assign rd_raw_o = ent_q[rd_ent_i];
endmodule

// File: rtl/colour_decode.sv
module colour_decode
  import palette_map_pkg::*;
(
  input  code_t raw_i,
  input  logic  flash_sel_i,
  input  logic  blank_i,
  output rgb_t  rgb_o
);
  code_t phys;
  logic  flip;

  always_comb begin
    phys  = raw_i ^ STORE_XOR;
    flip  = phys[CODE_W-1] & flash_sel_i;
    rgb_o = blank_i ? '0 : (phys[RGB_W-1:0] ^ {RGB_W{flip}});
  end
endmodule

// File: rtl/palette_map.sv
module palette_map
  import palette_map_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic [3:0] idx_i,
  input  logic       flash_sel_i,
  input  logic       blank_i,
  output logic [2:0] rgb_o
);
  wr_byte_t wb;
  code_t    rd_raw;
  rgb_t     rgb_d;
  rgb_t     rgb_q;

  assign wb = wr_byte_t'(wr_data_i);

  palette_store #(.ENTRIES(N_ENT)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_en_i  (wr_en_i),
    .wr_ent_i (wb.ent),
    .wr_raw_i (wb.raw),
    .rd_ent_i (idx_i),
    .rd_raw_o (rd_raw)
  );

  colour_decode u_dec (
    .raw_i       (rd_raw),
    .flash_sel_i (flash_sel_i),
    .blank_i     (blank_i),
    .rgb_o       (rgb_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rgb_q <= '0;
    else         rgb_q <= rgb_d;
  end

  assign rgb_o = rgb_q;
endmodule

// File: rtl/palette_map_chk.sv
module palette_map_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic [3:0] idx_i,
  input logic       flash_sel_i,
  input logic       blank_i,
  input logic [2:0] rgb_o
);
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end
  logic ready;
  assign ready = (age_q >= 2'd2);

  always @(negedge clk_i) begin
    if (!rst_ni) p_reset_black_r1: assert (rgb_o == 3'd0);
  end

  p_blank_black_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |=> (rgb_o == 3'd0));

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && idx_i == $past(idx_i) && flash_sel_i == $past(flash_sel_i) &&
     !blank_i && !$past(blank_i) && !$past(wr_en_i))
    |=> $stable(rgb_o));

  p_flash_pair_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready && idx_i == $past(idx_i) && flash_sel_i != $past(flash_sel_i) &&
     !blank_i && !$past(blank_i) && !$past(wr_en_i))
    |=> (rgb_o == $past(rgb_o) || rgb_o == ~$past(rgb_o)));
endmodule

bind palette_map palette_map_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .idx_i       (idx_i),
  .flash_sel_i (flash_sel_i),
  .blank_i     (blank_i),
  .rgb_o       (rgb_o)
);

// File: tb/palette_map_test.sv
module palette_map_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic [3:0] idx_i = '0;
  logic       flash_sel_i = 1'b0;
  logic       blank_i = 1'b0;
  logic [2:0] rgb_o;

  int checks = 0;
  int errors = 0;

  always #4 clk_i = ~clk_i;

  palette_map uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .idx_i(idx_i), .flash_sel_i(flash_sel_i), .blank_i(blank_i), .rgb_o(rgb_o)
  );

  // {wr_en, wr_data[7:0], idx[3:0], flash, blank, exp[2:0], req[3:0]}
  localparam int NV = 18;
  localparam logic [21:0] VEC [NV] = '{
    {1'b1, 8'h16, 4'd1,  1'b0, 1'b0, 3'd0, 4'd8},  // R8 write red to 1, old black seen
    {1'b0, 8'h00, 4'd1,  1'b0, 1'b0, 3'd1, 4'd2},  // R2 R3 red
    {1'b1, 8'h2E, 4'd1,  1'b0, 1'b0, 3'd1, 4'd3},  // entry 2 <- code 9
    {1'b0, 8'h00, 4'd2,  1'b0, 1'b0, 3'd1, 4'd4},  // R4 flash phase 0 red
    {1'b0, 8'h00, 4'd2,  1'b1, 1'b0, 3'd6, 4'd5},  // R5 flash phase 1 cyan
    {1'b0, 8'h00, 4'd2,  1'b1, 1'b1, 3'd0, 4'd6},  // R6 blank
    {1'b1, 8'h83, 4'd0,  1'b0, 1'b0, 3'd0, 4'd9},  // entry 8 <- blue
    {1'b0, 8'h00, 4'd8,  1'b0, 1'b0, 3'd4, 4'd2},  // R2 blue
    {1'b0, 8'h00, 4'd0,  1'b0, 1'b0, 3'd0, 4'd9},  // R9 entry 0 untouched
    {1'b1, 8'h30, 4'd3,  1'b0, 1'b1, 3'd0, 4'd10}, // R10 write while blank
    {1'b0, 8'h00, 4'd3,  1'b0, 1'b0, 3'd7, 4'd10}, // R10 white landed
    {1'b0, 8'h00, 4'd8,  1'b1, 1'b0, 3'd4, 4'd3},  // R3 steady ignores flash
    {1'b1, 8'h18, 4'd1,  1'b1, 1'b0, 3'd1, 4'd8},  // R8 entry 1 <- code 15, old red
    {1'b0, 8'h00, 4'd1,  1'b1, 1'b0, 3'd0, 4'd5},  // R5 ~white = black
    {1'b0, 8'h00, 4'd1,  1'b0, 1'b0, 3'd7, 4'd4},  // R4 white
    {1'b1, 8'h21, 4'd2,  1'b1, 1'b0, 3'd6, 4'd8},  // R8 entry 2 <- cyan, old code 9 flash
    {1'b0, 8'h00, 4'd2,  1'b1, 1'b0, 3'd6, 4'd3},  // R3 steady cyan
    {1'b0, 8'h00, 4'd15, 1'b0, 1'b0, 3'd0, 4'd1}   // R1 unwritten entry black
  };

  task automatic check(input logic [2:0] exp, input int req, input string what);
    checks++;
    if (rgb_o !== exp) begin
      errors++;
      $display("FAIL R%0d %s: rgb_o=%0d expected %0d", req, what, rgb_o, exp);
    end
  endtask

  task automatic read_idx(input logic [3:0] i, input logic f);
    @(negedge clk_i);
    wr_en_i = 1'b0; blank_i = 1'b0; idx_i = i; flash_sel_i = f;
    @(negedge clk_i);
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk_i);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    // R1 output low during reset
    repeat (3) @(negedge clk_i);
    check(3'd0, 1, "in reset");
    rst_ni = 1'b1;
    // R1 every entry black after reset
    for (int i = 0; i < 16; i++) begin
      read_idx(4'(i), 1'b1);
      check(3'd0, 1, "reset entry");
    end

    for (int v = 0; v < NV; v++) begin
      @(negedge clk_i);
      wr_en_i     = VEC[v][21];
      wr_data_i   = VEC[v][20:13];
      idx_i       = VEC[v][12:9];
      flash_sel_i = VEC[v][8];
      blank_i     = VEC[v][7];
      @(negedge clk_i);
      wr_en_i = 1'b0;
      check(VEC[v][6:4], int'(VEC[v][3:0]), $sformatf("vector %0d", v));
    end

    // R7 one-cycle latency: output changes only after the edge
    read_idx(4'd3, 1'b0);
    check(3'd7, 7, "settled white");
    idx_i = 4'd8;
    #2;
    check(3'd7, 7, "before edge");
    @(negedge clk_i);
    check(3'd4, 7, "after edge");

    // R9 neighbours of entry 8 in each bit untouched
    read_idx(4'd9, 1'b0);  check(3'd0, 9, "entry 9");
    read_idx(4'd10, 1'b0); check(3'd0, 9, "entry 10");
    read_idx(4'd12, 1'b0); check(3'd0, 9, "entry 12");

    // R1 reset mid-run clears loaded entries
    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(3'd0, 1, "async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    read_idx(4'd8, 1'b0); check(3'd0, 1, "entry 8 after reset");
    read_idx(4'd3, 1'b0); check(3'd0, 1, "entry 3 after reset");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule